// File: doc/BRIEF.md
# Packed Audio Word Unpacker

This block sits between an audio sample FIFO and a serial audio transmitter. The FIFO delivers 64-bit words, and each word carries several samples packed into equal lanes. The block takes one word at a time over a valid/ready handshake. It then hands the samples out one by one, also over valid/ready, starting with the lowest lane. Every sample leaves as a 24-bit left-justified value with a channel tag.

Three static configuration inputs set the behaviour. A packing kind sets how wide the lanes are and how many there are in a word. A top-bit position gives the sample width minus one, so it marks the highest valid bit inside a lane. A two-bit channel mask chooses between mono and alternating stereo. The configuration may change only while `enable` is low. Dropping `enable` throws away any word still held and restarts the channel phase.

Top module: `pcm_word_unpacker`

## Requirements
- R1: With `cfg_kind` = 0, a word holds eight 8-bit lanes. Lane k is `in_data[8k+7:8k]`, and the lanes come out in order k = 0 up to 7.
- R2: With `cfg_kind` = 2, a word holds four 16-bit lanes. Lane k is `in_data[16k+15:16k]`, and the lanes come out lowest first.
- R3: With `cfg_kind` = 4, a word holds two 32-bit lanes. Lane k is `in_data[32k+31:32k]`, and the lanes come out lowest first.
- R4: Lane bit `cfg_msb` appears at `out_sample[23]`, and lower lane bits follow it in order. Lane bits above `cfg_msb` are dropped. Output bits below the sample are zero. When `cfg_msb` > 23, the lowest `cfg_msb`-23 lane bits are dropped.
- R5: When `cfg_chmask` = 2'b11 (stereo), `out_right` is 0 on the first sample after enable and then toggles on every accepted sample. For any other mask value (mono), `out_right` stays 0.
- R6: A new word is accepted only once the last lane of the held word is leaving. `in_ready` is high in the same cycle as that last transfer, so a steady stream flows with no idle cycle on the output.
- R7: While `out_valid` is high and `out_ready` is low, `out_sample` and `out_right` hold their values.
- R8: Any `cfg_kind` other than 0, 2 or 4 gives exactly one all-zero sample per word. It also sets `err_sticky`, which stays high until reset, even across disable.
- R9: While `enable` is low, `in_ready` and `out_valid` are low. A word that was partly sent is discarded, and the next word starts at lane 0 on the left channel.
- R10: After reset (active-low, asynchronous), `out_valid`, `in_ready` and `err_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low clears held word and channel phase |
| cfg_kind | input | 3 | Packing kind: 0 = 8-bit lanes, 2 = 16-bit, 4 = 32-bit |
| cfg_msb | input | 5 | Sample width minus one (top valid bit within a lane) |
| cfg_chmask | input | 2 | Channel mask: 2'b11 stereo, otherwise mono |
| in_valid | input | 1 | Word available from FIFO |
| in_data | input | 64 | Packed word |
| in_ready | output | 1 | Word accepted this cycle when also valid |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Transmitter takes the sample |
| out_sample | output | 24 | Left-justified sample |
| out_right | output | 1 | Channel tag: 0 left, 1 right |
| err_sticky | output | 1 | Unsupported packing kind was used |

## Verification
The case to watch is the cycle in which the last lane of the held word leaves and the next word is loaded. Both happen in that one cycle. To make it happen, the bench holds `in_valid` and `out_ready` high through a run of 32-bit-lane words. In that run it checks every cycle that `out_valid` never drops. It also compares each sample against an independently computed queue, so a load that clobbered the final lane, or skipped it, shows up as a value or ordering mismatch. Random valid and ready gaps produce the same overlap in other alignments.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int WORD_W   = 64;
  localparam int SMP_W    = 24;
  localparam int POS_W    = 5;
  localparam int KIND_W   = 3;
  localparam int IDX_W    = 3;
  localparam int LANE_MAX = 32;

  localparam logic [KIND_W-1:0] KIND_B8  = 3'd0;
  localparam logic [KIND_W-1:0] KIND_B16 = 3'd2;
  localparam logic [KIND_W-1:0] KIND_B32 = 3'd4;

  function automatic logic kind_is_ok(input logic [KIND_W-1:0] k);
    return (k == KIND_B8) || (k == KIND_B16) || (k == KIND_B32);
  endfunction

  // Index of the final lane in a word for a packing kind
  function automatic logic [IDX_W-1:0] final_lane(input logic [KIND_W-1:0] k);
    case (k)
      KIND_B8:  return 3'd7;
      KIND_B16: return 3'd3;
      KIND_B32: return 3'd1;
      default:  return 3'd0;
    endcase
  endfunction

  // Right-justified lane contents, zero-extended
  function automatic logic [LANE_MAX-1:0] lane_raw(input logic [WORD_W-1:0] w,
                                                   input logic [KIND_W-1:0] k,
                                                   input logic [IDX_W-1:0]  idx);
    logic [WORD_W-1:0] s;
    logic [LANE_MAX-1:0] r;
    s = '0;
    r = '0;
    case (k)
      KIND_B8: begin
        s = w >> {idx, 3'b000};
        r = LANE_MAX'(s[7:0]);
      end
      KIND_B16: begin
        s = w >> {idx[1:0], 4'b0000};
        r = LANE_MAX'(s[15:0]);
      end
      KIND_B32: begin
        s = w >> {idx[0], 5'b00000};
        r = s[LANE_MAX-1:0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Keep bits [msb:0], then move bit msb to the output's top bit
  function automatic logic [SMP_W-1:0] align_top(input logic [LANE_MAX-1:0] v,
                                                 input logic [POS_W-1:0]    msb);
    logic [LANE_MAX-1:0] m;
    m = v & ~({LANE_MAX{1'b1}} << 1 << msb);
    if (int'(msb) >= SMP_W - 1)
      return SMP_W'(m >> (int'(msb) - (SMP_W - 1)));
    else
      return SMP_W'(m << ((SMP_W - 1) - int'(msb)));
  endfunction
endpackage

// File: rtl/unpk_lane_sel.sv
module unpk_lane_sel
  import unpk_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [KIND_W-1:0] kind,
  input  logic [POS_W-1:0]  msb,
  input  logic [IDX_W-1:0]  idx,
  output logic [SMP_W-1:0]  sample,
  output logic [IDX_W-1:0]  last_idx,
  output logic              kind_ok
);
  logic [LANE_MAX-1:0] raw;

  assign kind_ok  = kind_is_ok(kind);
  assign last_idx = final_lane(kind);
  assign raw      = lane_raw(word, kind, idx);
  assign sample   = kind_ok ? align_top(raw, msb) : '0;
endmodule

// File: rtl/unpk_seq.sv
module unpk_seq
  import unpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              stereo,
  input  logic              kind_ok,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] word_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              right_q,
  output logic              err_q
);
  logic have_q;
  logic at_last;
  logic pop;
  logic load;

  assign at_last   = (idx_q == last_idx);
  assign out_valid = enable && have_q;
  assign pop       = out_valid && out_ready;
  assign in_ready  = enable && (!have_q || (pop && at_last));
  assign load      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
      right_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (!enable) begin
      have_q  <= 1'b0;
      idx_q   <= '0;
      right_q <= 1'b0;
    end else begin
      if (load) begin
        word_q <= in_data;
        have_q <= 1'b1;
        idx_q  <= '0;
      end else if (pop && at_last) begin
        have_q <= 1'b0;
      end else if (pop) begin
        idx_q <= idx_q + 1'b1;
      end
      if (pop) begin
        right_q <= stereo && !right_q;
        if (!kind_ok) err_q <= 1'b1;
      end
    end
  end

  // R6
  hold_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !at_last) |-> !in_ready);
  // R6
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && at_last && in_valid) |=> (!enable || out_valid));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && enable) |=>
      (!enable || (out_valid && $stable(word_q) && $stable(idx_q) && $stable(right_q))));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!in_ready && !out_valid));
endmodule

// File: rtl/pcm_word_unpacker.sv
module pcm_word_unpacker
  import unpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [KIND_W-1:0] cfg_kind,
  input  logic [POS_W-1:0]  cfg_msb,
  input  logic [1:0]        cfg_chmask,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SMP_W-1:0]  out_sample,
  output logic              out_right,
  output logic              err_sticky
);
  logic              stereo;
  logic              kind_ok;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;

  assign stereo = (cfg_chmask == 2'b11);

  unpk_lane_sel lane_sel_i (
    .word     (word_q),
    .kind     (cfg_kind),
    .msb      (cfg_msb),
    .idx      (idx_q),
    .sample   (out_sample),
    .last_idx (last_idx),
    .kind_ok  (kind_ok)
  );

  unpk_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .stereo    (stereo),
    .kind_ok   (kind_ok),
    .last_idx  (last_idx),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .word_q    (word_q),
    .idx_q     (idx_q),
    .right_q   (out_right),
    .err_q     (err_sticky)
  );

  // R5
  mono_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_chmask != 2'b11) |-> !out_right);
  // R8
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_kind != 3'd0 && cfg_kind != 3'd2 && cfg_kind != 3'd4)
      |-> (out_sample == '0));
endmodule

// File: tb/pcm_word_unpacker_tb_top.sv
module pcm_word_unpacker_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  cfg_kind = 3'd0;
  logic [4:0]  cfg_msb = 5'd7;
  logic [1:0]  cfg_chmask = 2'b01;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_sample;
  logic        out_right;
  logic        err_sticky;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit exp_right = 1'b0;
  logic [24:0] expq[$];
  bit prev_stall = 1'b0;
  logic [24:0] prev_out = '0;

  always #(CLK_P/2) clk = ~clk;

  pcm_word_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_kind(cfg_kind),
    .cfg_msb(cfg_msb), .cfg_chmask(cfg_chmask), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample), .out_right(out_right),
    .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R1 R4 sample";
      3'd2: return "R2 R4 sample";
      3'd4: return "R3 R4 sample";
      default: return "R8 zero sample";
    endcase
  endfunction

  // Expected samples of one word, built bit by bit
  task automatic push_word(input logic [63:0] w);
    int lanes;
    int lw;
    case (cfg_kind)
      3'd0: begin lanes = 8; lw = 8; end
      3'd2: begin lanes = 4; lw = 16; end
      3'd4: begin lanes = 2; lw = 32; end
      default: begin lanes = 1; lw = 0; end
    endcase
    for (int l = 0; l < lanes; l++) begin
      logic [23:0] s;
      logic ch;
      s = '0;
      for (int b = 0; b < 24; b++) begin
        int src;
        src = int'(cfg_msb) - 23 + b;
        if (lw > 0 && src >= 0 && src <= int'(cfg_msb) && src < lw)
          s[b] = w[l*lw + src];
      end
      ch = (cfg_chmask == 2'b11) ? exp_right : 1'b0;
      if (cfg_chmask == 2'b11) exp_right = !exp_right;
      expq.push_back({ch, s});
    end
  endtask

  task automatic observe();
    if (prev_stall) chk("R7 stalled output held", {7'b0, out_right, out_sample}, {7'b0, prev_out});
    prev_stall = out_valid && !out_ready;
    prev_out = {out_right, out_sample};
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk("R6 unexpected sample", 32'd1, 32'd0);
      end else begin
        logic [24:0] e;
        e = expq.pop_front();
        chk(tag_of(cfg_kind), {8'b0, out_sample}, {8'b0, e[23:0]});
        chk("R5 channel tag", {31'b0, out_right}, {31'b0, e[24]});
      end
    end
    if (in_valid && in_ready) push_word(in_data);
  endtask

  task automatic run_cfg(input logic [2:0] k, input logic [4:0] msb, input logic [1:0] mask,
                         input int nwords, input int vp, input int rp, input bit stream);
    int sent;
    int cyc;
    bit acc;
    bit seen;
    @(negedge clk);
    cfg_kind = k; cfg_msb = msb; cfg_chmask = mask;
    enable = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    exp_right = 1'b0; expq.delete(); prev_stall = 1'b0;
    sent = 0; cyc = 0; acc = 1'b0; seen = 1'b0;
    while ((sent < nwords || expq.size() != 0) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (!in_valid || acc) begin
        in_valid = (sent < nwords) && (($urandom % 100) < vp);
        if (in_valid) in_data = {$urandom, $urandom};
      end
      out_ready = (($urandom % 100) < rp);
      #1;
      if (stream && seen && sent < nwords) chk("R6 no output bubble", {31'b0, out_valid}, 32'd1);
      if (out_valid) seen = 1'b1;
      acc = in_valid && in_ready;
      observe();
      if (acc) sent++;
    end
    chk("R6 all samples delivered", expq.size(), 32'd0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; enable = 1'b0;
    prev_stall = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_P * 2 + 1);
    // R10 reset state
    chk("R10 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R10 in_ready in reset", {31'b0, in_ready}, 32'd0);
    chk("R10 err in reset", {31'b0, err_sticky}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 idle in_ready", {31'b0, in_ready}, 32'd0);

    // Directed corner alignments, then random mixes
    run_cfg(3'd0, 5'd7,  2'b01, 30, 70, 60, 1'b0);
    run_cfg(3'd0, 5'd5,  2'b11, 30, 50, 80, 1'b0);
    run_cfg(3'd2, 5'd15, 2'b11, 30, 80, 50, 1'b0);
    run_cfg(3'd2, 5'd11, 2'b01, 30, 60, 60, 1'b0);
    run_cfg(3'd4, 5'd23, 2'b11, 30, 70, 70, 1'b0);
    run_cfg(3'd4, 5'd31, 2'b01, 30, 60, 40, 1'b0);
    run_cfg(3'd4, 5'd19, 2'b10, 30, 90, 90, 1'b0);
    run_cfg(3'd0, 5'd0,  2'b11, 20, 80, 80, 1'b0);
    for (int i = 0; i < 6; i++) begin
      logic [2:0] k;
      k = 3'(($urandom % 3) * 2);
      run_cfg(k, 5'($urandom), 2'($urandom), 20, 30 + $urandom % 70, 30 + $urandom % 70, 1'b0);
    end
    // R6 continuous stream: last lane and new load in one cycle
    run_cfg(3'd4, 5'd23, 2'b11, 40, 100, 100, 1'b1);
    run_cfg(3'd2, 5'd15, 2'b01, 20, 100, 100, 1'b1);
    chk("R8 no error on good kinds", {31'b0, err_sticky}, 32'd0);

    // R9 disable mid-word discards and restarts on left
    @(negedge clk);
    cfg_kind = 3'd0; cfg_msb = 5'd7; cfg_chmask = 2'b11;
    enable = 1'b1; exp_right = 1'b0; expq.delete();
    in_valid = 1'b1; in_data = 64'h8877_6655_4433_2211; out_ready = 1'b0;
    #1; observe();
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    #1; observe();
    @(negedge clk); out_ready = 1'b0; enable = 1'b0;
    #1;
    chk("R9 in_ready low when disabled", {31'b0, in_ready}, 32'd0);
    chk("R9 out_valid low when disabled", {31'b0, out_valid}, 32'd0);
    expq.delete(); exp_right = 1'b0; prev_stall = 1'b0;
    @(negedge clk); enable = 1'b1; in_valid = 1'b1; in_data = 64'h0102_0304_0506_07A5;
    #1; observe();
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk("R9 restart lane 0", {8'b0, out_sample}, {8'b0, 24'hA50000});
    chk("R9 restart on left", {31'b0, out_right}, 32'd0);
    observe();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1; observe();
    end
    chk("R9 word drained", expq.size(), 32'd0);
    @(negedge clk); out_ready = 1'b0; enable = 1'b0; prev_stall = 1'b0;

    // R8 unsupported kinds
    run_cfg(3'd5, 5'd23, 2'b11, 10, 70, 70, 1'b0);
    chk("R8 error flag set", {31'b0, err_sticky}, 32'd1);
    run_cfg(3'd1, 5'd7, 2'b01, 5, 70, 70, 1'b0);
    @(negedge clk); #1;
    chk("R8 error flag kept across disable", {31'b0, err_sticky}, 32'd1);
    rst_n = 1'b0; #1;
    chk("R10 reset clears error", {31'b0, err_sticky}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule